// File: doc/BRIEF.md
# Triggered Sample Capture Controller

This block is the recording engine of an on-chip logic analyzer. It watches a probe bus and stores one sample of it into on-chip memory each time a chosen edge appears on a separate sampling clock input. That input is sampled by the system clock, and either its rising or its falling transition can be selected as the sample edge. The host arms the engine. Once armed, the engine keeps writing samples into a ring. When a trigger hit coincides with a sample edge, it records a window of exactly one memory depth, starting with the sample taken at the trigger, and then stops.

After a window completes, a done flag is raised and stays up until the host arms again or a reset is applied. The host reads the window back by sample number: address 0 is the sample taken at the trigger, and higher addresses follow in capture order. The physical memory slot that holds the trigger sample is also reported. The engine can be re-armed after every completed window without any reconfiguration. Trigger-condition evaluation and the host link are outside this block.

Top module: `trig_capture`

## Requirements
- R1: A synchronous active-low reset puts the engine in the idle state, clears the done flag, the window sample count, the write pointer and `trig_slot` (to 0), and forgets the previous sampling-clock level (taken as 0).
- R2: `smp_clk` is registered by `clk`. With `edge_sel`=0, a sample edge is a cycle in which `smp_clk` is 1 and its registered value is 0. With `edge_sel`=1, a sample edge is a cycle in which `smp_clk` is 0 and its registered value is 1. At most one sample is stored per sample edge.
- R3: `arm` high in the idle or done state moves the engine to armed on the next clock and clears `cap_done`. `arm` in the armed or capturing state has no effect.
- R4: `trig_hit` is ignored unless the engine is armed and the same cycle is a sample edge.
- R5: In the armed state, a sample edge with `trig_hit` high stores that sample, moves the engine to capturing, and sets `trig_slot` to the memory slot that sample was written into.
- R6: After DEPTH = 2**ADDR_W samples have been stored, counting the trigger sample, the engine enters done and `cap_done` is 1. `cap_done` stays 1 and memory is not written until `arm` or reset.
- R7: `rd_data` is registered. One clock after `rd_addr` is presented, it holds sample number `rd_addr` of the last window, where sample 0 is the trigger sample.
- R8: The write pointer advances by one, modulo DEPTH, on every sample edge in the armed and capturing states. Arming does not reset it.
- R9: `cap_state` reports the state as 0 = idle, 1 = armed, 2 = capturing, 3 = done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_clk | input | 1 | Sampling clock, observed as data |
| edge_sel | input | 1 | 0 selects the rising sample edge, 1 the falling |
| probe | input | DATA_W | Probe bus being recorded |
| trig_hit | input | 1 | Trigger match from external match logic |
| arm | input | 1 | Arm command |
| rd_addr | input | ADDR_W | Readback sample number relative to the trigger |
| rd_data | output | DATA_W | Stored sample, valid one clock after rd_addr |
| cap_state | output | 2 | Engine state encoding |
| cap_done | output | 1 | Window complete |
| trig_slot | output | ADDR_W | Memory slot holding the trigger sample |

## Verification
The bench builds the block with ADDR_W=3 and DATA_W=8. An eight-entry window fills in a few dozen cycles, so many complete arm-trigger-readback rounds fit in one run. With that depth, random pre-trigger stretches carry the write pointer round the ring many times, which exercises the modulo readback translation and a trigger slot that differs from window to window. Randomly toggled sampling-clock levels and switching between the two edge selections cover cycles with no sample edge in the middle of a capture.

// File: rtl/cap_pkg.sv
// Shared types for the triggered capture engine.
// Assumes nothing beyond a 2-bit state encoding visible at the top ports.
package cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } cap_st_t;
endpackage

// File: rtl/cap_edge_pick.sv
// Turns a slow sampling-clock level into a single-cycle sample strobe.
// Assumes smp_clk changes slowly relative to clk; the previous level resets to 0.
module cap_edge_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_clk,
    input  logic edge_sel,
    output logic strobe
);
    logic lvl_q;

    // Remember the sampling-clock level seen at the previous system edge.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= smp_clk;
    end

    // Select the rising or the falling transition as the sample edge.
    always_comb begin
        if (edge_sel) strobe = lvl_q & ~smp_clk;
        else          strobe = ~lvl_q & smp_clk;
    end
endmodule

// File: rtl/cap_seq.sv
// Sequencer: arm / trigger / window-fill state machine and the ring pointers.
// Assumes a window of DEPTH = 2**ADDR_W samples and ADDR_W >= 1.
module cap_seq
    import cap_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              trig_hit,
    input  logic              arm,
    output cap_st_t           state,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic [ADDR_W-1:0] trig_ptr
);
    localparam logic [ADDR_W-1:0] LAST_CNT = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] win_cnt;

    // Memory is written on every sample edge while armed or capturing.
    always_comb begin
        wr_en = strobe && (state == ST_ARMED || state == ST_CAPT);
    end

    // State, ring pointer, trigger slot and window count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            wr_ptr   <= '0;
            trig_ptr <= '0;
            win_cnt  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            unique case (state)
                ST_IDLE, ST_DONE: begin
                    if (arm) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    if (strobe && trig_hit) begin
                        trig_ptr <= wr_ptr;
                        win_cnt  <= {{(ADDR_W-1){1'b0}}, 1'b1};
                        state    <= ST_CAPT;
                    end
                end
                ST_CAPT: begin
                    if (strobe) begin
                        if (win_cnt == LAST_CNT) state <= ST_DONE;
                        else                     win_cnt <= win_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cap_store.sv
// Sample memory: one write port, one registered read port.
// Assumes read and write do not target the same slot in one cycle in use.
module cap_store #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store the probe sample in its ring slot.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read of the requested slot.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/trig_capture.sv
// Top of the triggered capture engine: edge picker, sequencer and memory.
// Readback addresses are relative to the trigger slot and wrap modulo DEPTH.
module trig_capture
    import cap_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_clk,
    input  logic              edge_sel,
    input  logic [DATA_W-1:0] probe,
    input  logic              trig_hit,
    input  logic              arm,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        cap_state,
    output logic              cap_done,
    output logic [ADDR_W-1:0] trig_slot
);
    logic              smp_strobe;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] trig_ptr;
    logic [ADDR_W-1:0] phys_rd;
    cap_st_t           state;

    cap_edge_pick u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_clk  (smp_clk),
        .edge_sel (edge_sel),
        .strobe   (smp_strobe)
    );

    cap_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (smp_strobe),
        .trig_hit (trig_hit),
        .arm      (arm),
        .state    (state),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .trig_ptr (trig_ptr)
    );

    // Translate a trigger-relative sample number into a ring slot.
    always_comb begin
        phys_rd = trig_ptr + rd_addr;
    end

    cap_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_ptr),
        .wr_data (probe),
        .rd_addr (phys_rd),
        .rd_data (rd_data)
    );

    // Drive the status outputs from the sequencer.
    always_comb begin
        cap_state = state;
        cap_done  = (state == ST_DONE);
        trig_slot = trig_ptr;
    end
endmodule

// File: rtl/cap_checker.sv
// Protocol checks for trig_capture, attached by bind.
// Assumes it sees the top's ports plus the internal sample strobe.
module cap_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic              trig_hit,
    input logic              strobe,
    input logic [1:0]        cap_state,
    input logic              cap_done,
    input logic [ADDR_W-1:0] trig_slot
);
    logic seen_clk;
    logic rst_prev;

    // Track one elapsed edge and the reset level seen at it.
    always_ff @(posedge clk) begin
        seen_clk <= 1'b1;
        rst_prev <= rst_n;
    end

    // R1
    always @(posedge clk) begin
        if (seen_clk === 1'b1 && rst_prev === 1'b0)
            reset_idle_chk: assert (cap_state == 2'd0 && !cap_done && trig_slot == '0);
    end

    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == 2'd0 && !arm) |=> (cap_state == 2'd0));

    // R3
    arm_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cap_state == 2'd0 || cap_state == 2'd3) && arm) |=> (cap_state == 2'd1 && !cap_done));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == 2'd3 && !arm) |=> (cap_state == 2'd3 && cap_done));

    // R5
    armed_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == 2'd1 && !(strobe && trig_hit)) |=> (cap_state == 2'd1));

    // R5
    slot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_state == 2'd2) |=> $stable(trig_slot));
endmodule

bind trig_capture cap_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .trig_hit  (trig_hit),
    .strobe    (smp_strobe),
    .cap_state (cap_state),
    .cap_done  (cap_done),
    .trig_slot (trig_slot)
);

// File: tb/sim_trig_capture.sv
module sim_trig_capture;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_clk = 1'b0;
    logic          edge_sel = 1'b0;
    logic [DW-1:0] probe = '0;
    logic          trig_hit = 1'b0;
    logic          arm = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [1:0]    cap_state;
    logic          cap_done;
    logic [AW-1:0] trig_slot;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    int      m_st = 0;
    int      m_ptr = 0;
    int      m_trig = 0;
    int      m_cnt = 0;
    bit      m_prev = 0;
    logic [DW-1:0] m_mem [D];

    always #2 clk = ~clk;

    trig_capture #(.DATA_W(DW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_clk(smp_clk), .edge_sel(edge_sel),
        .probe(probe), .trig_hit(trig_hit), .arm(arm), .rd_addr(rd_addr),
        .rd_data(rd_data), .cap_state(cap_state), .cap_done(cap_done),
        .trig_slot(trig_slot)
    );

    function automatic void model_edge();
        bit stb;
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_trig = 0; m_cnt = 0; m_prev = 0;
            return;
        end
        stb = edge_sel ? (m_prev && !smp_clk) : (!m_prev && smp_clk);
        m_prev = smp_clk;
        case (m_st)
            0, 3: if (arm) m_st = 1;
            1: if (stb) begin
                m_mem[m_ptr] = probe;
                if (trig_hit) begin m_trig = m_ptr; m_cnt = 1; m_st = 2; end
                m_ptr = (m_ptr + 1) % D;
            end
            2: if (stb) begin
                m_mem[m_ptr] = probe;
                m_ptr = (m_ptr + 1) % D;
                if (m_cnt == D - 1) m_st = 3; else m_cnt++;
            end
            default: ;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: inputs already set at a negedge; model at posedge; compare at next negedge.
    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " R9 state"}, int'(cap_state), m_st);
        check({tag, " R6 done"}, int'(cap_done), int'(m_st == 3));
        check({tag, " R8 slot"}, int'(trig_slot), m_trig);
    endtask

    task automatic readback(input string tag);
        arm = 0; trig_hit = 0;
        for (int i = 0; i < D; i++) begin
            rd_addr = AW'(i);
            step(tag);
            check({tag, " R7 rdata"}, int'(rd_data), int'(m_mem[(m_trig + i) % D]));
        end
    endtask

    // Random capture round with pre-trigger activity and stray commands.
    task automatic random_round(input int n);
        int guard;
        edge_sel = 1'($urandom_range(0, 1));
        step("R2 esel");
        arm = 1; step("R3 arm"); arm = 0;
        guard = 0;
        while (m_st != 3 && guard < 400) begin
            smp_clk  = 1'($urandom_range(0, 1));
            probe    = DW'($urandom);
            trig_hit = ($urandom_range(0, 5) == 0);
            arm      = ($urandom_range(0, 9) == 0);
            step("R5 rnd");
            guard++;
        end
        arm = 0; trig_hit = 0;
        check("R6 window completes", int'(m_st == 3), 1);
        readback("R7 rnd");
        if (n % 4 == 0) begin
            trig_hit = 1; smp_clk = ~smp_clk; step("R4 trig in done"); trig_hit = 0;
        end
    endtask

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        rst_n = 0;
        step("R1 rst"); step("R1 rst");
        check("R1 reset state", int'(cap_state), 0);
        check("R1 reset slot", int'(trig_slot), 0);
        rst_n = 1;

        // R4: trigger at a sample edge while idle is ignored
        trig_hit = 1; smp_clk = 1; step("R4 idle trig");
        check("R4 still idle", int'(cap_state), 0);
        trig_hit = 0; smp_clk = 0; step("R4 idle");

        // R2/R5: rising edge; a low level with trig does not start capture
        edge_sel = 0; arm = 1; step("R3 arm"); arm = 0;
        trig_hit = 1; smp_clk = 0; step("R2 no edge");
        check("R2 no edge keeps armed", int'(cap_state), 1);
        probe = 8'hA5; smp_clk = 1; step("R5 trig");
        check("R5 capturing", int'(cap_state), 2);
        trig_hit = 0;
        // R3: arm while capturing is ignored
        arm = 1; smp_clk = 1; step("R3 arm ignored"); arm = 0;
        check("R3 arm ignored in capture", int'(cap_state), 2);
        for (int i = 1; i < D; i++) begin
            probe = DW'(8'h10 + i);
            smp_clk = 0; step("R2 low");
            smp_clk = 1; step("R2 rise");
        end
        check("R6 done after depth", int'(cap_done), 1);
        readback("R7 dir");
        rd_addr = '0; step("R7"); check("R5 sample 0 is trigger", int'(rd_data), 8'hA5);

        // R2: falling edge, pointer continues (R8)
        edge_sel = 1; smp_clk = 1; step("R2 fall setup");
        arm = 1; step("R3 rearm"); arm = 0;
        check("R3 rearm clears done", int'(cap_done), 0);
        smp_clk = 0; probe = 8'h01; step("R8 pretrig");
        smp_clk = 1; step("R2 rise ignored");
        smp_clk = 0; probe = 8'h3C; trig_hit = 1; step("R5 fall trig"); trig_hit = 0;
        check("R8 slot moved", int'(trig_slot), 1);
        while (m_st != 3) begin
            smp_clk = ~smp_clk; probe = DW'($urandom); step("R2 fall run");
        end
        readback("R7 fall");

        for (int n = 0; n < 40; n++) random_round(n);

        // R1: reset in the middle of a capture
        edge_sel = 0; arm = 1; step("R3"); arm = 0;
        smp_clk = 0; step("R1 pre"); smp_clk = 1; trig_hit = 1; step("R1 trig"); trig_hit = 0;
        rst_n = 0; step("R1 mid"); rst_n = 1;
        check("R1 mid-capture reset", int'(cap_state), 0);

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule